// File: doc/BRIEF.md
# ATA Device Task-File Register Unit

This block is the device-side register file of a parallel ATA disk port. The host reaches it through two chip selects, a 3-bit register address and one-cycle read and write strobes. It decodes these into the command-block registers (the parameter registers, Error/Features and Status/Command) and into the control-block register (Alternate Status/Device Control). The block drives read data and the interrupt line back to the host, and it takes part in master/slave selection through a strap input.

A device-side controller works on the other face of the block. It loads Status and Error, raises interrupts, and receives a one-cycle pulse with the opcode whenever the selected device accepts a command byte. The parameter registers are offered to it as plain outputs. The Drive/Head byte is one of them, and its low nibble holds LBA bits 27:24 when LBA addressing is in use. Cable timing, DMA handshaking and the execution of media commands lie outside this block.

Top module: `ata_taskfile_regs`

## Requirements
- R1: With only `host_cs_cmd` high, writes to address 2 (count), 3 (sector), 4 (cylinder low), 5 (cylinder high) and 6 (drive/head) are stored, read back at the same address, and appear on the matching `tf_*` output. A write to address 1 goes to Features (`tf_features`). A read of address 1 returns Error.
- R2: Status uses bit 7 busy, 6 ready, 5 write fault, 4 seek done, 3 data request, 2 corrected, 1 index and 0 error. The controller loads it with `ctl_status_we`. The host reads it at command-block address 7 and, as Alternate Status, at control-block address 6. The controller loads Error with `ctl_error_we`, and the host reads it back unchanged.
- R3: While Status bit 7 is 1, a read of any command-block address from 1 to 7 returns Status.
- R4: A write to command-block address 7 on the selected device, outside soft reset, pulses `cmd_valid` for one cycle after the write edge with `cmd_code` equal to the byte written. At the same edge it sets Status bit 7 and clears the pending interrupt.
- R5: `host_intrq` is high only when an interrupt is pending, the device is selected and Device Control bit 1 (interrupt disable) is 0. A pending interrupt survives while it is disabled.
- R6: A selected read of Status at address 7 clears the pending interrupt. A read of Alternate Status does not.
- R7: While Device Control bit 2 (soft reset) is 1, `soft_reset` is high, Status reads 0x80, the pending interrupt is cleared, and controller status loads and interrupt raises are ignored. After the bit is released, Status stays 0x80 until the controller loads it.
- R8: An invalid access is ignored on write and, on read, returns `IDLE_VAL` (default 0xFF) with `host_rdata_oe` low. Invalid accesses are: both chip selects high, neither high, command-block address 0, and a control-block address other than 6.
- R9: The device is selected when Drive/Head bit 4 equals `strap_slave`. A non-selected device keeps `host_rdata_oe` and `host_intrq` low, ignores command writes and leaves the interrupt pending on Status reads. It still stores parameter and Device Control writes.
- R10: After reset, Status is 0x00, Error 0x01, count 0x01, sector 0x01, the other parameter registers 0x00, no interrupt is pending, and interrupt disable and soft reset are 0.
- R11: If the controller raises an interrupt in the same cycle as a clearing Status read, the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_slave | input | 1 | 0 = device answers drive-select 0, 1 = drive-select 1 |
| host_cs_cmd | input | 1 | Command-block chip select, active high |
| host_cs_ctl | input | 1 | Control-block chip select, active high |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, `IDLE_VAL` when not driven |
| host_rdata_oe | output | 1 | Device drives the data bus |
| host_intrq | output | 1 | Interrupt request to host |
| ctl_status_we | input | 1 | Controller Status load |
| ctl_status_d | input | 8 | Controller Status value |
| ctl_error_we | input | 1 | Controller Error load |
| ctl_error_d | input | 8 | Controller Error value |
| ctl_irq_set | input | 1 | Controller raises an interrupt |
| cmd_valid | output | 1 | One-cycle accepted-command pulse |
| cmd_code | output | 8 | Last accepted command byte |
| tf_features | output | 8 | Features register |
| tf_count | output | 8 | Sector count register |
| tf_sector | output | 8 | Sector number register |
| tf_cyl_lo | output | 8 | Cylinder low register |
| tf_cyl_hi | output | 8 | Cylinder high register |
| tf_devhead | output | 8 | Drive/Head register, low nibble LBA 27:24 |
| soft_reset | output | 1 | Soft reset held by host |

## Verification
A wrong pending-interrupt state shows on `host_intrq` in the cycle after the strobe that should have set or cleared it, unless selection or the interrupt-disable bit masks it. The bench therefore toggles those gates without clearing the interrupt, so that a hidden pending state becomes visible. A stuck busy bit turns every parameter read into a Status read. A lost busy bit lets parameter bytes through where Status should appear. Both show on the first read after a command write. A decoder that accepts an invalid address corrupts a register, and the next valid read of that register exposes it.

// File: rtl/ata_tf_pkg.sv
// Package: shared constants and types for the ATA task-file register unit.
// Assumes an 8-bit register width and a 3-bit register address.
package ata_tf_pkg;
    localparam int TF_W  = 8;
    localparam int TF_AW = 3;
    typedef logic [TF_W-1:0] tf_byte_t;

    // Register addresses (command block unless noted)
    localparam logic [TF_AW-1:0] A_ERRFEAT = 3'd1;
    localparam logic [TF_AW-1:0] A_COUNT   = 3'd2;
    localparam logic [TF_AW-1:0] A_SECTOR  = 3'd3;
    localparam logic [TF_AW-1:0] A_CYLLO   = 3'd4;
    localparam logic [TF_AW-1:0] A_CYLHI   = 3'd5;
    localparam logic [TF_AW-1:0] A_DEVHEAD = 3'd6;
    localparam logic [TF_AW-1:0] A_STATCMD = 3'd7;
    localparam logic [TF_AW-1:0] A_ALTCTL  = 3'd6;   // control block
    localparam int P_FIRST = 1;
    localparam int P_LAST  = 6;

    // Bit positions
    localparam int ST_BSY  = 7;
    localparam int DC_SRST = 2;
    localparam int DC_NIEN = 1;
    localparam int DH_DEV  = 4;

    localparam tf_byte_t ST_RESET   = 8'h00;
    localparam tf_byte_t ER_RESET   = 8'h01;
    localparam tf_byte_t ST_IN_SRST = 8'h80;

    typedef struct packed {
        logic param;    // command-block address 1..6
        logic statcmd;  // command-block address 7
        logic altctl;   // control-block address 6
    } tf_hit_t;

    function automatic tf_byte_t param_reset(input int idx);
        return (idx == int'(A_COUNT) || idx == int'(A_SECTOR)) ? 8'h01 : 8'h00;
    endfunction
endpackage

// File: rtl/ata_tf_decode.sv
// Module: address decoder. Turns the two chip selects and the address into
// one-hot register hits. Assumes both selects high or both low are invalid.
module ata_tf_decode
    import ata_tf_pkg::*;
(
    input  logic             cs_cmd,
    input  logic             cs_ctl,
    input  logic [TF_AW-1:0] addr,
    output tf_hit_t          hit
);
    // Decode one access into at most one register hit
    always_comb begin
        hit = '0;
        if (cs_cmd && !cs_ctl) begin
            hit.param   = (addr != '0) && (addr != A_STATCMD);
            hit.statcmd = (addr == A_STATCMD);
        end
        if (cs_ctl && !cs_cmd) begin
            hit.altctl = (addr == A_ALTCTL);
        end
    end
endmodule

// File: rtl/ata_tf_param_regs.sv
// Module: host-written parameter registers at command-block addresses 1..6.
// Assumes the write enable is already qualified by a valid decode.
module ata_tf_param_regs
    import ata_tf_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [TF_AW-1:0]            addr,
    input  tf_byte_t                    wdata,
    output tf_byte_t [P_LAST:P_FIRST]   regs_q
);
    for (genvar g = P_FIRST; g <= P_LAST; g++) begin : g_reg
        tf_byte_t q;
        // Store the host byte when this register's address is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= param_reset(g);
            end else if (wr_en && addr == TF_AW'(g)) begin
                q <= wdata;
            end
        end
        assign regs_q[g] = q;
    end
endmodule

// File: rtl/ata_tf_status.sv
// Module: Status, Error and pending-interrupt state. The controller loads
// Status and Error; an accepted command forces busy; soft reset overrides.
// Assumes cmd_go and rd_clear are already qualified by selection.
module ata_tf_status
    import ata_tf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     srst,
    input  logic     cmd_go,
    input  logic     rd_clear,
    input  logic     ctl_status_we,
    input  tf_byte_t ctl_status_d,
    input  logic     ctl_error_we,
    input  tf_byte_t ctl_error_d,
    input  logic     ctl_irq_set,
    output tf_byte_t status_q,
    output tf_byte_t error_q,
    output logic     pending_q
);
    tf_byte_t status_nxt;

    // Next Status: controller load, then busy forced by a command
    always_comb begin
        status_nxt = ctl_status_we ? ctl_status_d : status_q;
        if (cmd_go) status_nxt[ST_BSY] = 1'b1;
    end

    // Status register with soft-reset override
    always_ff @(posedge clk) begin
        if (!rst_n)    status_q <= ST_RESET;
        else if (srst) status_q <= ST_IN_SRST;
        else           status_q <= status_nxt;
    end

    // Error register, written only by the controller
    always_ff @(posedge clk) begin
        if (!rst_n)            error_q <= ER_RESET;
        else if (ctl_error_we) error_q <= ctl_error_d;
    end

    // Pending interrupt: raise wins over clear, soft reset clears
    always_ff @(posedge clk) begin
        if (!rst_n)                  pending_q <= 1'b0;
        else if (srst)               pending_q <= 1'b0;
        else if (ctl_irq_set)        pending_q <= 1'b1;
        else if (cmd_go || rd_clear) pending_q <= 1'b0;
    end

    assert_cmd_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !srst) |=> status_q[ST_BSY]);
    assert_srst_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (status_q == ST_IN_SRST) && !pending_q);
    assert_raise_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_irq_set && !srst) |=> pending_q);
endmodule

// File: rtl/ata_taskfile_regs.sv
// Module: top of the ATA device task-file register unit. Decodes host
// accesses, holds Device Control, gates read data and INTRQ by drive
// selection, and hands accepted commands to the controller.
// Assumes one-cycle host strobes synchronous to clk.
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter logic [7:0] IDLE_VAL = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_slave,
    input  logic       host_cs_cmd,
    input  logic       host_cs_ctl,
    input  logic [2:0] host_addr,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_rdata_oe,
    output logic       host_intrq,
    input  logic       ctl_status_we,
    input  logic [7:0] ctl_status_d,
    input  logic       ctl_error_we,
    input  logic [7:0] ctl_error_d,
    input  logic       ctl_irq_set,
    output logic       cmd_valid,
    output logic [7:0] cmd_code,
    output logic [7:0] tf_features,
    output logic [7:0] tf_count,
    output logic [7:0] tf_sector,
    output logic [7:0] tf_cyl_lo,
    output logic [7:0] tf_cyl_hi,
    output logic [7:0] tf_devhead,
    output logic       soft_reset
);
    tf_hit_t                    hit;
    tf_byte_t [P_LAST:P_FIRST]  param_q;
    tf_byte_t                   status_q, error_q, rd_val;
    logic                       pending_q, nien_q, srst_q, selected;
    logic                       cmd_go, rd_clear, any_hit;

    ata_tf_decode u_dec (
        .cs_cmd (host_cs_cmd),
        .cs_ctl (host_cs_ctl),
        .addr   (host_addr),
        .hit    (hit)
    );

    ata_tf_param_regs u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (host_wr && hit.param),
        .addr   (host_addr),
        .wdata  (host_wdata),
        .regs_q (param_q)
    );

    assign selected = (param_q[A_DEVHEAD][DH_DEV] == strap_slave);
    assign any_hit  = hit.param || hit.statcmd || hit.altctl;
    assign cmd_go   = host_wr && hit.statcmd && selected && !srst_q;
    assign rd_clear = host_rd && hit.statcmd && selected;

    ata_tf_status u_st (
        .clk           (clk),
        .rst_n         (rst_n),
        .srst          (srst_q),
        .cmd_go        (cmd_go),
        .rd_clear      (rd_clear),
        .ctl_status_we (ctl_status_we),
        .ctl_status_d  (ctl_status_d),
        .ctl_error_we  (ctl_error_we),
        .ctl_error_d   (ctl_error_d),
        .ctl_irq_set   (ctl_irq_set),
        .status_q      (status_q),
        .error_q       (error_q),
        .pending_q     (pending_q)
    );

    // Device Control: both devices latch it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nien_q <= 1'b0;
            srst_q <= 1'b0;
        end else if (host_wr && hit.altctl) begin
            nien_q <= host_wdata[DC_NIEN];
            srst_q <= host_wdata[DC_SRST];
        end
    end

    // Command hand-off pulse and opcode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
        end else begin
            cmd_valid <= cmd_go;
            if (cmd_go) cmd_code <= host_wdata;
        end
    end

    // Read mux: Status when busy, at address 7 or as Alternate Status
    always_comb begin
        rd_val = status_q;
        if (hit.param && !status_q[ST_BSY]) begin
            case (host_addr)
                A_ERRFEAT: rd_val = error_q;
                A_COUNT:   rd_val = param_q[A_COUNT];
                A_SECTOR:  rd_val = param_q[A_SECTOR];
                A_CYLLO:   rd_val = param_q[A_CYLLO];
                A_CYLHI:   rd_val = param_q[A_CYLHI];
                default:   rd_val = param_q[A_DEVHEAD];
            endcase
        end
    end

    assign host_rdata_oe = host_rd && selected && any_hit;
    assign host_rdata    = host_rdata_oe ? rd_val : IDLE_VAL;
    assign host_intrq    = pending_q && selected && !nien_q;

    assign tf_features = param_q[A_ERRFEAT];
    assign tf_count    = param_q[A_COUNT];
    assign tf_sector   = param_q[A_SECTOR];
    assign tf_cyl_lo   = param_q[A_CYLLO];
    assign tf_cyl_hi   = param_q[A_CYLHI];
    assign tf_devhead  = param_q[A_DEVHEAD];
    assign soft_reset  = srst_q;

    assert_nien_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit.altctl && host_wdata[DC_NIEN]) |=> !host_intrq);
    assert_stat_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !ctl_irq_set && !host_wr) |=> !host_intrq);
    assert_alt_read_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && host_rd && hit.altctl && !host_wr && !srst_q) |=> pending_q);
    assert_invalid_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !any_hit) |=> $stable(param_q) && $stable(nien_q) && $stable(srst_q));
    assert_unselected_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit.statcmd && !selected) |=> !cmd_valid);
endmodule

// File: tb/ata_taskfile_regs_tb.sv
// Bench: table walk over register accesses, then directed tests.
module ata_taskfile_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_slave = 1'b0;
    logic       host_cs_cmd = 0, host_cs_ctl = 0, host_rd = 0, host_wr = 0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rdata_oe, host_intrq;
    logic       ctl_status_we = 0, ctl_error_we = 0, ctl_irq_set = 0;
    logic [7:0] ctl_status_d = '0, ctl_error_d = '0;
    logic       cmd_valid, soft_reset;
    logic [7:0] cmd_code, tf_features, tf_count, tf_sector, tf_cyl_lo, tf_cyl_hi, tf_devhead;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    ata_taskfile_regs dut_i (.*);

    // {req[3:0], rd, cs_cmd, cs_ctl, addr[2:0], data[7:0], exp_oe, exp[7:0]}
    localparam int NV = 20;
    localparam logic [26:0] VEC [NV] = '{
        {4'd1, 1'b0, 1'b1, 1'b0, 3'd2, 8'h05, 1'b0, 8'h00},
        {4'd1, 1'b1, 1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 8'h05},
        {4'd1, 1'b0, 1'b1, 1'b0, 3'd3, 8'h11, 1'b0, 8'h00},
        {4'd1, 1'b1, 1'b1, 1'b0, 3'd3, 8'h00, 1'b1, 8'h11},
        {4'd1, 1'b0, 1'b1, 1'b0, 3'd4, 8'h22, 1'b0, 8'h00},
        {4'd1, 1'b1, 1'b1, 1'b0, 3'd4, 8'h00, 1'b1, 8'h22},
        {4'd1, 1'b0, 1'b1, 1'b0, 3'd5, 8'h33, 1'b0, 8'h00},
        {4'd1, 1'b1, 1'b1, 1'b0, 3'd5, 8'h00, 1'b1, 8'h33},
        {4'd1, 1'b0, 1'b1, 1'b0, 3'd6, 8'hE7, 1'b0, 8'h00},
        {4'd1, 1'b1, 1'b1, 1'b0, 3'd6, 8'h00, 1'b1, 8'hE7},
        {4'd1, 1'b0, 1'b1, 1'b0, 3'd1, 8'h9C, 1'b0, 8'h00},
        {4'd1, 1'b1, 1'b1, 1'b0, 3'd1, 8'h00, 1'b1, 8'h01},
        {4'd8, 1'b0, 1'b1, 1'b1, 3'd2, 8'h77, 1'b0, 8'h00},
        {4'd8, 1'b1, 1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 8'h05},
        {4'd8, 1'b1, 1'b1, 1'b1, 3'd2, 8'h00, 1'b0, 8'hFF},
        {4'd8, 1'b1, 1'b0, 1'b0, 3'd7, 8'h00, 1'b0, 8'hFF},
        {4'd8, 1'b1, 1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 8'hFF},
        {4'd8, 1'b0, 1'b0, 1'b1, 3'd5, 8'h0E, 1'b0, 8'h00},
        {4'd2, 1'b1, 1'b0, 1'b1, 3'd6, 8'h00, 1'b1, 8'h00},
        {4'd2, 1'b1, 1'b1, 1'b0, 3'd7, 8'h00, 1'b1, 8'h00}
    };

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic c0, input logic c1, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_cs_cmd = c0; host_cs_ctl = c1; host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; host_cs_cmd = 1'b0; host_cs_ctl = 1'b0;
    endtask

    task automatic hread(input logic c0, input logic c1, input logic [2:0] a,
                         output logic [7:0] d, output logic oe);
        @(negedge clk);
        host_cs_cmd = c0; host_cs_ctl = c1; host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata; oe = host_rdata_oe;
        @(posedge clk); #1;
        host_rd = 1'b0; host_cs_cmd = 1'b0; host_cs_ctl = 1'b0;
    endtask

    task automatic ctl_status(input logic [7:0] v);
        @(negedge clk); ctl_status_we = 1'b1; ctl_status_d = v;
        @(posedge clk); #1 ctl_status_we = 1'b0;
    endtask

    task automatic ctl_error(input logic [7:0] v);
        @(negedge clk); ctl_error_we = 1'b1; ctl_error_d = v;
        @(posedge clk); #1 ctl_error_we = 1'b0;
    endtask

    task automatic irq_pulse();
        @(negedge clk); ctl_irq_set = 1'b1;
        @(posedge clk); #1 ctl_irq_set = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic oe;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        hread(1, 0, 3'd7, d, oe); chk("R10 status", {oe, d}, {1'b1, 8'h00});
        hread(1, 0, 3'd1, d, oe); chk("R10 error", {oe, d}, {1'b1, 8'h01});
        hread(1, 0, 3'd2, d, oe); chk("R10 count", {oe, d}, {1'b1, 8'h01});
        hread(1, 0, 3'd3, d, oe); chk("R10 sector", {oe, d}, {1'b1, 8'h01});
        hread(1, 0, 3'd4, d, oe); chk("R10 cyl lo", {oe, d}, {1'b1, 8'h00});
        chk("R10 intrq/srst", {7'd0, host_intrq, soft_reset}, 9'd0);

        // Table walk: R1, R8, R2
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            if (v[22]) begin
                hread(v[21], v[20], v[19:17], d, oe);
                chk($sformatf("R%0d row %0d", v[26:23], i), {oe, d}, {v[8], v[7:0]});
            end else begin
                hwrite(v[21], v[20], v[19:17], v[16:9]);
            end
        end
        chk("R1 tf_features", {1'b0, tf_features}, {1'b0, 8'h9C});
        chk("R1 tf_devhead LBA nibble", {1'b0, tf_devhead}, {1'b0, 8'hE7});
        chk("R8 no soft reset from bad addr", {8'd0, soft_reset}, 9'd0);

        // R2 controller loads, R5 / R6 interrupt behaviour
        ctl_status(8'h58);
        ctl_error(8'h04);
        hread(1, 0, 3'd1, d, oe); chk("R2 error readback", {oe, d}, {1'b1, 8'h04});
        irq_pulse();
        chk("R5 intrq raised", {8'd0, host_intrq}, 9'd1);
        hread(0, 1, 3'd6, d, oe); chk("R2 alt status", {oe, d}, {1'b1, 8'h58});
        chk("R6 alt read keeps intrq", {8'd0, host_intrq}, 9'd1);
        hread(1, 0, 3'd7, d, oe); chk("R2 status", {oe, d}, {1'b1, 8'h58});
        chk("R6 status read clears", {8'd0, host_intrq}, 9'd0);

        hwrite(0, 1, 3'd6, 8'h0A);
        irq_pulse();
        chk("R5 nIEN masks", {8'd0, host_intrq}, 9'd0);
        hwrite(0, 1, 3'd6, 8'h08);
        chk("R5 pending kept under mask", {8'd0, host_intrq}, 9'd1);

        // R11 raise and clearing read in the same cycle
        @(negedge clk);
        host_cs_cmd = 1; host_addr = 3'd7; host_rd = 1; ctl_irq_set = 1;
        @(posedge clk); #1;
        host_rd = 0; host_cs_cmd = 0; ctl_irq_set = 0;
        chk("R11 raise beats clear", {8'd0, host_intrq}, 9'd1);

        // R9 drive selection
        hwrite(1, 0, 3'd6, 8'hF7);
        chk("R9 unselected intrq", {8'd0, host_intrq}, 9'd0);
        hread(1, 0, 3'd7, d, oe); chk("R9 unselected read", {oe, d}, {1'b0, 8'hFF});
        hwrite(1, 0, 3'd7, 8'h20);
        chk("R9 unselected cmd ignored", {8'd0, cmd_valid}, 9'd0);
        hwrite(1, 0, 3'd6, 8'hE7);
        chk("R9 pending kept while unselected", {8'd0, host_intrq}, 9'd1);
        hread(1, 0, 3'd7, d, oe); chk("R9 no busy from ignored cmd", {oe, d}, {1'b1, 8'h58});

        // R4 command acceptance
        irq_pulse();
        hwrite(1, 0, 3'd7, 8'hEC);
        chk("R4 cmd_valid", {cmd_valid, cmd_code}, {1'b1, 8'hEC});
        chk("R4 cmd clears intrq", {8'd0, host_intrq}, 9'd0);
        @(posedge clk); #1;
        chk("R4 cmd_valid one cycle", {8'd0, cmd_valid}, 9'd0);

        // R3 busy reads
        hread(1, 0, 3'd2, d, oe); chk("R3 busy read count", {oe, d}, {1'b1, 8'hD8});
        hread(1, 0, 3'd1, d, oe); chk("R3 busy read error", {oe, d}, {1'b1, 8'hD8});
        ctl_status(8'h50);
        hread(1, 0, 3'd2, d, oe); chk("R3 not busy count", {oe, d}, {1'b1, 8'h05});

        // R7 soft reset
        hwrite(0, 1, 3'd6, 8'h0C);
        chk("R7 soft_reset high", {8'd0, soft_reset}, 9'd1);
        ctl_status(8'h50);
        irq_pulse();
        hread(0, 1, 3'd6, d, oe); chk("R7 status in reset", {oe, d}, {1'b1, 8'h80});
        chk("R7 no irq in reset", {8'd0, host_intrq}, 9'd0);
        hwrite(0, 1, 3'd6, 8'h08);
        chk("R7 soft_reset released", {8'd0, soft_reset}, 9'd0);
        hread(1, 0, 3'd7, d, oe); chk("R7 busy after release", {oe, d}, {1'b1, 8'h80});
        ctl_status(8'h50);
        hread(1, 0, 3'd7, d, oe); chk("R7 controller reload", {oe, d}, {1'b1, 8'h50});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule